// File: doc/BRIEF.md
# Bus Cycle Break Condition Matcher

This block observes every cycle on a bus that is shared by a CPU and a DMA controller. It compares each cycle against a set of compare channels (four by default). A channel looks at the cycle's address and, if asked to, its data. Each of these comparisons has a per-bit mask. The channel also checks four qualifiers: which master drove the cycle, whether it is an instruction fetch or a data access, its direction, and its access size. A channel matches only when every selected condition holds. A match sets that channel's sticky condition flag.

The block raises a one-cycle break interrupt in one of two modes. In independent mode it fires on any channel match. In sequential mode it fires only when the enabled channels match in ascending index order over successive bus cycles. There is one exception to the one-step-per-cycle rule: two neighbouring channels in the sequence that are both pre-execution instruction-fetch conditions may both complete in one cycle.

A small register port configures the block and lets software read and clear the flags. Only the CPU can use this port.

Top module: `bus_break_matcher`

## Requirements
- R1: A channel's address compare ignores every address bit whose mask bit is 1 and needs equality on every other bit. Channel c uses these word addresses on the register port: c*8+0 compare address, c*8+1 address mask, c*8+2 compare data, c*8+3 data mask, c*8+4 qualifier.
- R2: When qualifier bit 9 is set, the data is compared under its mask (mask bit 1 means don't care). Only the active lanes count, taken from the low bits: 8 bits for bus_size 0 (byte), 16 bits for 1 (word), 32 bits for 2 (long).
- R3: Qualifier fields: bit 0 enable. Bits 2:1 master (1 CPU, 2 DMA). Bits 4:3 kind (1 fetch, 2 data). Bits 6:5 direction (1 read, 2 write). Bits 8:7 size (1 byte, 2 word, 3 long). In each field, 0 or 3 means any; for size, 0 means any. Every field that is set must hold.
- R4: A DMA-mastered cycle always counts as a data access, even if bus_fetch is high. A channel that selects DMA master together with fetch kind therefore never matches and never sets its flag.
- R5: A channel whose enable bit is 0 never matches, never sets its flag, and never takes part in a break.
- R6: The flags are read at word address 0x21, with bit c for channel c. A match sets its bit. A bit stays set until a CPU write to 0x21 carries 0 in that bit; a 1 leaves the bit unchanged. A match in the same cycle as a clearing write wins.
- R7: In independent mode (bit 0 at word address 0x20 is 0), brk_irq is high in the cycle after any cycle in which a channel matched. It is high for exactly one cycle per matching bus cycle.
- R8: In sequential mode (bit 0 at 0x20 is 1), the enabled channels form a sequence in ascending index order. Each bus cycle can advance the sequence by one step, and only on a match of the channel now expected. Matches of other channels do not change progress. brk_irq pulses one cycle after the last channel of the sequence matches in turn, and the sequence then starts over.
- R9: In sequential mode, a cycle in which the expected channel and the next channel both match, and both are instruction-fetch conditions with qualifier bit 10 (pre-execution) set, advances past both. A break fires if that completes the sequence.
- R10: Register-port accesses with reg_dma high change nothing and read back zero.
- R11: After reset, every register reads zero and brk_irq is low.
- R12: Any accepted CPU write to a channel register or to 0x20 returns the sequence to its first channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_dma | input | 1 | Cycle master: 1 DMA controller, 0 CPU |
| bus_fetch | input | 1 | 1 instruction fetch, 0 data access |
| bus_write | input | 1 | 1 write, 0 read |
| bus_size | input | 2 | 0 byte, 1 word, 2 long |
| bus_addr | input | 32 | Cycle address |
| bus_data | input | 32 | Cycle data, active lanes in the low bits |
| reg_sel | input | 1 | Register access this clock |
| reg_we | input | 1 | 1 write, 0 read |
| reg_dma | input | 1 | Access originates from the DMA controller |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, same cycle as reg_sel |
| brk_irq | output | 1 | Break interrupt pulse |

## Verification
Single channels are driven with cycles that differ from a matching cycle in exactly one attribute: one unmasked address bit, one data nibble, one lane, the master, the kind, the direction or the size. Each such cycle shows whether that one comparison is gated as intended. Sequential runs use the expected order, the reversed order, repeated first-channel hits, and a progress reset by a configuration write in the middle of a sequence; these separate correct stepping from a plain any-match OR. Single fetch cycles are tried with the pre-execution bit set on both channels and then on only one, which shows whether the same-cycle double step is taken only under its rule.

// File: rtl/bbm_pkg.sv
// Shared widths, encodings and configuration types of the break matcher.
package bbm_pkg;
    localparam int AW = 32;
    localparam int DW = 32;

    // two-bit selector values shared by the master, kind and direction fields
    localparam logic [1:0] SEL_ANY = 2'd0;
    localparam logic [1:0] SEL_A   = 2'd1;   // CPU / fetch / read
    localparam logic [1:0] SEL_B   = 2'd2;   // DMA / data / write

    // bus_size encoding
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;

    // word offsets inside a channel's register slot
    localparam logic [2:0] OFF_ADDR  = 3'd0;
    localparam logic [2:0] OFF_AMASK = 3'd1;
    localparam logic [2:0] OFF_DATA  = 3'd2;
    localparam logic [2:0] OFF_DMASK = 3'd3;
    localparam logic [2:0] OFF_QUAL  = 3'd4;

    // word offsets inside the global slot
    localparam logic [2:0] GOFF_CTRL = 3'd0;
    localparam logic [2:0] GOFF_FLAG = 3'd1;

    typedef struct packed {
        logic       pre_exec;
        logic       data_en;
        logic [1:0] size;
        logic [1:0] dir;
        logic [1:0] kind;
        logic [1:0] master;
        logic       enable;
    } qual_t;

    localparam int QW = $bits(qual_t);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] amask;
        logic [DW-1:0] data;
        logic [DW-1:0] dmask;
        qual_t         qual;
    } chan_cfg_t;
endpackage

// File: rtl/bbm_chan_cmp.sv
// One compare channel: purely combinational. Decides whether the present
// bus cycle meets the channel's masked address, optional masked data and
// qualifier conditions. Assumes bus data arrives lane-aligned to bit 0.
module bbm_chan_cmp
    import bbm_pkg::*;
(
    input  chan_cfg_t     cfg,
    input  logic          bus_valid,
    input  logic          bus_dma,
    input  logic          bus_fetch,
    input  logic          bus_write,
    input  logic [1:0]    bus_size,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    output logic          hit,
    output logic          fetch_pre
);
    logic          is_fetch;
    logic          master_ok, kind_ok, dir_ok, size_ok, addr_ok, data_ok;
    logic [DW-1:0] lane;

    // a DMA cycle is never an instruction fetch
    assign is_fetch = bus_fetch & ~bus_dma;

    // active byte lanes for the data compare
    always_comb begin
        lane = '0;
        case (bus_size)
            SZ_BYTE: lane[7:0]  = '1;
            SZ_WORD: lane[15:0] = '1;
            default: lane       = '1;
        endcase
    end

    // qualifier checks, each either selected or don't-care
    always_comb begin
        master_ok = (cfg.qual.master == SEL_A) ? ~bus_dma :
                    (cfg.qual.master == SEL_B) ?  bus_dma : 1'b1;
        kind_ok   = (cfg.qual.kind == SEL_A) ?  is_fetch :
                    (cfg.qual.kind == SEL_B) ? ~is_fetch : 1'b1;
        dir_ok    = (cfg.qual.dir == SEL_A) ? ~bus_write :
                    (cfg.qual.dir == SEL_B) ?  bus_write : 1'b1;
        size_ok   = (cfg.qual.size == 2'd0) || ((cfg.qual.size - 2'd1) == bus_size);
    end

    // masked address and data comparisons
    assign addr_ok = ((bus_addr ^ cfg.addr) & ~cfg.amask) == '0;
    assign data_ok = ~cfg.qual.data_en ||
                     (((bus_data ^ cfg.data) & ~cfg.dmask & lane) == '0);

    assign hit = bus_valid & cfg.qual.enable & master_ok & kind_ok &
                 dir_ok & size_ok & addr_ok & data_ok;

    // marks an enabled pre-execution instruction-fetch condition
    assign fetch_pre = cfg.qual.enable & cfg.qual.pre_exec & (cfg.qual.kind == SEL_A);
endmodule

// File: rtl/bbm_regs.sv
// Register file of the matcher: channel configuration, mode bit and the
// sticky flags, with a same-cycle read path. Only CPU accesses take effect.
// Assumes NUM_CH >= 2 and RA_W = clog2(NUM_CH) + 4.
module bbm_regs
    import bbm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int RA_W   = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_sel,
    input  logic                  reg_we,
    input  logic                  reg_dma,
    input  logic [RA_W-1:0]       reg_addr,
    input  logic [DW-1:0]         reg_wdata,
    input  logic [NUM_CH-1:0]     hit_vec,
    output chan_cfg_t [NUM_CH-1:0] cfg,
    output logic                  seq_mode,
    output logic [NUM_CH-1:0]     flags,
    output logic [DW-1:0]         reg_rdata,
    output logic                  cfg_wr
);
    localparam int CH_W = RA_W - 4;

    logic            cpu_acc, cpu_wr, is_glob, flag_wr;
    logic [CH_W-1:0] ch_idx;
    logic [2:0]      off;

    assign cpu_acc = reg_sel & ~reg_dma;
    assign cpu_wr  = cpu_acc & reg_we;
    assign is_glob = reg_addr[RA_W-1];
    assign ch_idx  = reg_addr[RA_W-2:3];
    assign off     = reg_addr[2:0];
    assign flag_wr = cpu_wr & is_glob & (off == GOFF_FLAG);
    assign cfg_wr  = cpu_wr & (~is_glob | (off == GOFF_CTRL));

    // channel configuration storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (cpu_wr && !is_glob) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (ch_idx == CH_W'(c)) begin
                    case (off)
                        OFF_ADDR:  cfg[c].addr  <= reg_wdata[AW-1:0];
                        OFF_AMASK: cfg[c].amask <= reg_wdata[AW-1:0];
                        OFF_DATA:  cfg[c].data  <= reg_wdata;
                        OFF_DMASK: cfg[c].dmask <= reg_wdata;
                        OFF_QUAL:  cfg[c].qual  <= qual_t'(reg_wdata[QW-1:0]);
                        default:   ;
                    endcase
                end
            end
        end
    end

    // mode bit: 1 selects sequential breaks
    always_ff @(posedge clk) begin
        if (!rst_n)
            seq_mode <= 1'b0;
        else if (cpu_wr && is_glob && off == GOFF_CTRL)
            seq_mode <= reg_wdata[0];
    end

    // sticky flags: set by a match, cleared by a written 0, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= (flag_wr ? (flags & reg_wdata[NUM_CH-1:0]) : flags) | hit_vec;
    end

    // read mux, zero for idle or DMA-originated accesses
    always_comb begin
        reg_rdata = '0;
        if (cpu_acc) begin
            if (is_glob) begin
                case (off)
                    GOFF_CTRL: reg_rdata[0]        = seq_mode;
                    GOFF_FLAG: reg_rdata[NUM_CH-1:0] = flags;
                    default:   ;
                endcase
            end else begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (ch_idx == CH_W'(c)) begin
                        case (off)
                            OFF_ADDR:  reg_rdata[AW-1:0] = cfg[c].addr;
                            OFF_AMASK: reg_rdata[AW-1:0] = cfg[c].amask;
                            OFF_DATA:  reg_rdata         = cfg[c].data;
                            OFF_DMASK: reg_rdata         = cfg[c].dmask;
                            OFF_QUAL:  reg_rdata[QW-1:0] = cfg[c].qual;
                            default:   ;
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/bbm_seq.sv
// Break decision. Independent mode: any channel hit fires. Sequential mode:
// enabled channels must hit in ascending order; a stored stage names the
// lowest channel index still allowed to be next. Assumes hits are already
// gated by bus_valid and enable.
module bbm_seq #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_mode,
    input  logic              cfg_wr,
    input  logic [NUM_CH-1:0] en_vec,
    input  logic [NUM_CH-1:0] fp_vec,
    input  logic [NUM_CH-1:0] hit_vec,
    output logic              fire
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [CH_W-1:0] stage, nxt_stage;

    // next-step and fire decision for the present cycle
    always_comb begin
        int  cur, last, p, n;
        logic found, going, seek;
        fire      = 1'b0;
        nxt_stage = stage;
        cur   = 0;
        last  = 0;
        p     = 0;
        n     = 0;
        found = 1'b0;
        going = 1'b0;
        seek  = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (en_vec[c]) last = c;
            if (en_vec[c] && !found && c >= int'(stage)) begin
                cur   = c;
                found = 1'b1;
            end
        end
        if (!seq_mode) begin
            fire      = |hit_vec;
            nxt_stage = '0;
        end else if (found && hit_vec[cur]) begin
            p     = cur;
            going = 1'b1;
            for (int k = 0; k < NUM_CH; k++) begin
                if (going) begin
                    if (p == last) begin
                        fire      = 1'b1;
                        nxt_stage = '0;
                        going     = 1'b0;
                    end else begin
                        n    = p;
                        seek = 1'b1;
                        for (int c = 0; c < NUM_CH; c++) begin
                            if (seek && c > p && en_vec[c]) begin
                                n    = c;
                                seek = 1'b0;
                            end
                        end
                        nxt_stage = CH_W'(n);
                        if (hit_vec[n] && fp_vec[p] && fp_vec[n])
                            p = n;
                        else
                            going = 1'b0;
                    end
                end
            end
        end
    end

    // stage register, restarted by any configuration write
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_wr)
            stage <= '0;
        else
            stage <= nxt_stage;
    end
endmodule

// File: rtl/bus_break_matcher.sv
// Top of the break matcher: register file, one comparator per channel,
// the sequencer and the registered break pulse. Assumes a single clock
// shared with the observed bus and NUM_CH >= 2.
module bus_break_matcher
    import bbm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int RA_W   = $clog2(NUM_CH) + 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_valid,
    input  logic            bus_dma,
    input  logic            bus_fetch,
    input  logic            bus_write,
    input  logic [1:0]      bus_size,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_data,
    input  logic            reg_sel,
    input  logic            reg_we,
    input  logic            reg_dma,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            brk_irq
);
    chan_cfg_t [NUM_CH-1:0] cfg;
    logic                   seq_mode, cfg_wr, fire;
    logic [NUM_CH-1:0]      flags_q, hit_vec, fp_vec, en_vec;

    bbm_regs #(.NUM_CH(NUM_CH), .RA_W(RA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_dma   (reg_dma),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .hit_vec   (hit_vec),
        .cfg       (cfg),
        .seq_mode  (seq_mode),
        .flags     (flags_q),
        .reg_rdata (reg_rdata),
        .cfg_wr    (cfg_wr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        assign en_vec[c] = cfg[c].qual.enable;
        bbm_chan_cmp u_cmp (
            .cfg       (cfg[c]),
            .bus_valid (bus_valid),
            .bus_dma   (bus_dma),
            .bus_fetch (bus_fetch),
            .bus_write (bus_write),
            .bus_size  (bus_size),
            .bus_addr  (bus_addr),
            .bus_data  (bus_data),
            .hit       (hit_vec[c]),
            .fetch_pre (fp_vec[c])
        );
    end

    bbm_seq #(.NUM_CH(NUM_CH)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .seq_mode (seq_mode),
        .cfg_wr   (cfg_wr),
        .en_vec   (en_vec),
        .fp_vec   (fp_vec),
        .hit_vec  (hit_vec),
        .fire     (fire)
    );

    // break pulse, one cycle after the deciding bus cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            brk_irq <= 1'b0;
        else
            brk_irq <= fire;
    end
endmodule

// File: rtl/bbm_checker.sv
// Property checker for the break matcher, attached by bind. Observes the
// ports plus the flag, enable, hit and mode signals between the submodules.
module bbm_checker #(
    parameter int NUM_CH = 4,
    parameter int RA_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              reg_sel,
    input logic              reg_we,
    input logic              reg_dma,
    input logic [RA_W-1:0]   reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              brk_irq,
    input logic              seq_mode,
    input logic [NUM_CH-1:0] flags_q,
    input logic [NUM_CH-1:0] en_vec,
    input logic [NUM_CH-1:0] hit_vec
);
    localparam logic [RA_W-1:0] FLAG_ADDR = {1'b1, {(RA_W-2){1'b0}}, 1'b1};

    logic [NUM_CH-1:0] last_oh;

    // one-hot marker of the highest enabled channel
    always_comb begin
        last_oh = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (en_vec[c]) last_oh = NUM_CH'(1) << c;
    end

    AST_IRQ_AFTER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_irq |-> $past(bus_valid)); // R7

    AST_DMA_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_dma) |-> (reg_rdata == '0)); // R10

    AST_FLAG_CLEAR_ONLY_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(flags_q) & ~flags_q)) |->
        $past(reg_sel && reg_we && !reg_dma && reg_addr == FLAG_ADDR)); // R6

    AST_FLAG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q & ~$past(flags_q) & ~$past(en_vec)) == '0); // R5

    AST_IND_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_irq && !$past(seq_mode)) |-> (flags_q != '0)); // R7

    AST_SEQ_IRQ_LAST_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_irq && $past(seq_mode)) |-> (|($past(hit_vec) & $past(last_oh)))); // R8
endmodule

bind bus_break_matcher bbm_checker #(.NUM_CH(NUM_CH), .RA_W(RA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .reg_sel   (reg_sel),
    .reg_we    (reg_we),
    .reg_dma   (reg_dma),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .brk_irq   (brk_irq),
    .seq_mode  (seq_mode),
    .flags_q   (flags_q),
    .en_vec    (en_vec),
    .hit_vec   (hit_vec)
);

// File: tb/bus_break_matcher_test.sv
// Bench: behavioural reference model compared with the read data and the
// break pulse on every clock.
module bus_break_matcher_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bv = 0, bd = 0, bf = 0, bw = 0;
    logic [1:0]  bs = 0;
    logic [31:0] ba = 0, bdat = 0;
    logic        rs = 0, rwe = 0, rdma = 0;
    logic [5:0]  ra = 0;
    logic [31:0] rwd = 0;
    logic [31:0] reg_rdata;
    logic        brk_irq;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    logic [31:0] m_addr[4], m_amask[4], m_data[4], m_dmask[4];
    logic [10:0] m_qual[4];
    bit          m_seq;
    logic [3:0]  m_flags;
    int          m_pos;

    bus_break_matcher uut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bv), .bus_dma(bd), .bus_fetch(bf), .bus_write(bw),
        .bus_size(bs), .bus_addr(ba), .bus_data(bdat),
        .reg_sel(rs), .reg_we(rwe), .reg_dma(rdma), .reg_addr(ra),
        .reg_wdata(rwd), .reg_rdata(reg_rdata), .brk_irq(brk_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int c = 0; c < 4; c++) begin
            m_addr[c] = 0; m_amask[c] = 0; m_data[c] = 0; m_dmask[c] = 0; m_qual[c] = 0;
        end
        m_seq = 0; m_flags = 0; m_pos = 0;
    endfunction

    function automatic bit mhit(int c);
        logic [10:0] q = m_qual[c];
        bit fetch = bf && !bd;
        logic [31:0] lm;
        if (!bv || !q[0]) return 0;
        if (q[2:1] == 1 && bd) return 0;
        if (q[2:1] == 2 && !bd) return 0;
        if (q[4:3] == 1 && !fetch) return 0;
        if (q[4:3] == 2 && fetch) return 0;
        if (q[6:5] == 1 && bw) return 0;
        if (q[6:5] == 2 && !bw) return 0;
        if (q[8:7] != 0 && int'(q[8:7]) - 1 != int'(bs)) return 0;
        if (((ba ^ m_addr[c]) & ~m_amask[c]) != 0) return 0;
        lm = (bs == 0) ? 32'h0000_00FF : (bs == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
        if (q[9] && (((bdat ^ m_data[c]) & ~m_dmask[c] & lm) != 0)) return 0;
        return 1;
    endfunction

    function automatic bit mfp(int c);
        return m_qual[c][0] && m_qual[c][10] && m_qual[c][4:3] == 1;
    endfunction

    function automatic logic [31:0] mread();
        int c;
        if (!rs || rdma) return 0;
        if (ra[5]) begin
            if (ra[2:0] == 0) return {31'd0, m_seq};
            if (ra[2:0] == 1) return {28'd0, m_flags};
            return 0;
        end
        c = int'(ra[4:3]);
        case (ra[2:0])
            0: return m_addr[c];
            1: return m_amask[c];
            2: return m_data[c];
            3: return m_dmask[c];
            4: return {21'd0, m_qual[c]};
            default: return 0;
        endcase
    endfunction

    // one clock: check read data, predict, step the model, check the pulse
    task automatic tick(string tag);
        logic [31:0] er;
        bit [3:0] h;
        bit efire = 0;
        int np, p;
        int q[$];
        bit cfgw = 0;
        #1;
        er = mread();
        check(reg_rdata === er, tag, "rdata", reg_rdata, er);
        for (int c = 0; c < 4; c++) h[c] = mhit(c);
        np = m_pos;
        if (!m_seq) begin
            efire = |h;
            np = 0;
        end else begin
            for (int c = 0; c < 4; c++) if (m_qual[c][0]) q.push_back(c);
            if (q.size() > 0 && m_pos < q.size() && h[q[m_pos]]) begin
                p = m_pos;
                while (1) begin
                    p++;
                    if (p == q.size()) begin efire = 1; np = 0; break; end
                    if (h[q[p]] && mfp(q[p-1]) && mfp(q[p])) continue;
                    np = p;
                    break;
                end
            end
        end
        @(posedge clk);
        if (!rst_n) begin
            model_reset();
            efire = 0;
        end else begin
            if (rs && rwe && !rdma && ra == 6'h21) m_flags = m_flags & rwd[3:0];
            m_flags = m_flags | h;
            m_pos = np;
            if (rs && rwe && !rdma) begin
                if (ra[5]) begin
                    if (ra[2:0] == 0) begin m_seq = rwd[0]; cfgw = 1; end
                end else begin
                    cfgw = 1;
                    case (ra[2:0])
                        0: m_addr[ra[4:3]]  = rwd;
                        1: m_amask[ra[4:3]] = rwd;
                        2: m_data[ra[4:3]]  = rwd;
                        3: m_dmask[ra[4:3]] = rwd;
                        4: m_qual[ra[4:3]]  = rwd[10:0];
                        default: ;
                    endcase
                end
                if (cfgw) m_pos = 0;
            end
        end
        #1;
        check(brk_irq === efire, tag, "brk_irq", {31'd0, brk_irq}, {31'd0, efire});
        @(negedge clk);
        bv = 0; rs = 0; rwe = 0; rdma = 0;
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d, string tag, bit dma = 0);
        rs = 1; rwe = 1; rdma = dma; ra = a; rwd = d;
        tick(tag);
    endtask

    task automatic rd(logic [5:0] a, string tag, bit dma = 0);
        rs = 1; rwe = 0; rdma = dma; ra = a;
        tick(tag);
    endtask

    task automatic cyc(bit dma, bit fetch, bit write, logic [1:0] size,
                       logic [31:0] addr, logic [31:0] data, string tag);
        bv = 1; bd = dma; bf = fetch; bw = write; bs = size; ba = addr; bdat = data;
        tick(tag);
    endtask

    function automatic logic [31:0] qual(int en, int ms, int kd, int dr, int sz, int de, int pe);
        return 32'(en | (ms << 1) | (kd << 3) | (dr << 5) | (sz << 7) | (de << 9) | (pe << 10));
    endfunction

    task automatic setch(int c, logic [31:0] a, logic [31:0] am, logic [31:0] d,
                         logic [31:0] dm, logic [31:0] q, string tag);
        wr(6'(c * 8 + 0), a, tag);
        wr(6'(c * 8 + 1), am, tag);
        wr(6'(c * 8 + 2), d, tag);
        wr(6'(c * 8 + 3), dm, tag);
        wr(6'(c * 8 + 4), q, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        for (int i = 0; i < 3; i++) tick("R11");
        rst_n = 1;
        // R11: reset values
        rd(6'h20, "R11"); rd(6'h21, "R11"); rd(6'h00, "R11"); rd(6'h04, "R11");

        // R1: masked address compare
        setch(0, 32'h0031_4156, 0, 0, 0, qual(1, 0, 0, 0, 0, 0, 0), "R1");
        cyc(0, 0, 0, 2, 32'h0031_4156, 0, "R1");
        cyc(0, 0, 0, 2, 32'h0031_4157, 0, "R1");
        wr(6'h01, 32'h0000_00FF, "R1");
        cyc(0, 0, 0, 2, 32'h0031_41AA, 0, "R1");
        cyc(0, 0, 0, 2, 32'h0031_42AA, 0, "R1");
        wr(6'h04, 0, "R1");

        // R2 / R3: data lanes and qualifiers
        setch(1, 32'h0005_5555, 0, 32'h7878, 32'h0F0F, qual(1, 2, 2, 2, 1, 1, 0), "R2");
        cyc(1, 0, 1, 0, 32'h0005_5555, 32'h7A, "R2");
        cyc(1, 0, 1, 0, 32'h0005_5555, 32'h8A, "R2");
        cyc(1, 0, 0, 0, 32'h0005_5555, 32'h7A, "R3");
        cyc(0, 0, 1, 0, 32'h0005_5555, 32'h7A, "R3");
        cyc(1, 0, 1, 1, 32'h0005_5555, 32'h7A, "R3");
        cyc(1, 1, 1, 0, 32'h0005_5555, 32'h7A, "R3");
        wr(6'h0C, qual(1, 2, 2, 2, 0, 1, 0), "R2");
        cyc(1, 0, 1, 1, 32'h0005_5555, 32'hAAAA_7C7D, "R2");
        cyc(1, 0, 1, 0, 32'h0005_5555, 32'h0000_1178, "R2");
        cyc(1, 0, 1, 2, 32'h0005_5555, 32'h0001_7878, "R2");
        cyc(1, 0, 1, 2, 32'h0005_5555, 32'h0000_7171, "R2");
        rd(6'h21, "R6");
        wr(6'h0C, 0, "R2");

        // R4: DMA plus fetch never matches
        setch(2, 0, 32'hFFFF_FFFF, 0, 0, qual(1, 2, 1, 0, 0, 0, 0), "R4");
        cyc(1, 1, 0, 0, 32'h100, 0, "R4");
        cyc(1, 0, 0, 0, 32'h100, 0, "R4");
        cyc(0, 1, 0, 2, 32'h100, 0, "R4");
        rd(6'h21, "R4");
        wr(6'h14, 0, "R4");

        // R5: disabled channel matches nothing
        setch(3, 0, 32'hFFFF_FFFF, 0, 0, qual(0, 0, 0, 0, 0, 0, 0), "R5");
        cyc(0, 0, 0, 2, 32'h1234, 0, "R5");
        cyc(1, 0, 1, 0, 32'h5678, 0, "R5");
        rd(6'h21, "R5");

        // R6: sticky flags, write-0 clear, set wins
        wr(6'h21, 32'hF, "R6"); rd(6'h21, "R6");
        wr(6'h21, 32'hE, "R6"); rd(6'h21, "R6");
        setch(0, 0, 32'hFFFF_FFFF, 0, 0, qual(1, 0, 0, 0, 0, 0, 0), "R6");
        bv = 1; bd = 0; bf = 0; bw = 0; bs = 2; ba = 32'h40; bdat = 0;
        rs = 1; rwe = 1; rdma = 0; ra = 6'h21; rwd = 0;
        tick("R6");
        rd(6'h21, "R6");

        // R7: one pulse per matching cycle
        cyc(0, 0, 0, 2, 32'h44, 0, "R7");
        tick("R7");
        cyc(0, 0, 1, 2, 32'h48, 0, "R7");
        cyc(0, 1, 0, 2, 32'h4C, 0, "R7");
        tick("R7");

        // R10: DMA-originated register accesses
        wr(6'h20, 1, "R10", 1);
        rd(6'h20, "R10");
        rd(6'h04, "R10", 1);
        wr(6'h00, 32'h1234, "R10", 1);
        rd(6'h00, "R10");
        wr(6'h21, 0, "R10", 1);
        rd(6'h21, "R10");

        // R8: ordered sequence over channels 0 and 1
        setch(0, 32'h1000, 0, 0, 0, qual(1, 0, 0, 0, 0, 0, 0), "R8");
        setch(1, 32'h2000, 0, 0, 0, qual(1, 0, 0, 0, 0, 0, 0), "R8");
        wr(6'h20, 1, "R8");
        cyc(0, 0, 0, 2, 32'h2000, 0, "R8");
        cyc(0, 0, 0, 2, 32'h1000, 0, "R8");
        cyc(0, 0, 0, 2, 32'h2000, 0, "R8");
        tick("R8");
        cyc(0, 0, 0, 2, 32'h1000, 0, "R8");
        cyc(0, 0, 0, 2, 32'h1000, 0, "R8");
        cyc(0, 0, 0, 2, 32'h2000, 0, "R8");
        cyc(0, 0, 0, 2, 32'h2000, 0, "R8");

        // R12: configuration write restarts the sequence
        cyc(0, 0, 0, 2, 32'h1000, 0, "R12");
        wr(6'h20, 1, "R12");
        cyc(0, 0, 0, 2, 32'h2000, 0, "R12");
        cyc(0, 0, 0, 2, 32'h1000, 0, "R12");
        cyc(0, 0, 0, 2, 32'h2000, 0, "R12");

        // R9: simultaneous pre-execution fetch matches
        setch(0, 0, 32'hFFFF_FFFF, 0, 0, qual(1, 0, 1, 0, 0, 0, 1), "R9");
        setch(1, 0, 32'hFFFF_FFFF, 0, 0, qual(1, 0, 1, 0, 0, 0, 1), "R9");
        cyc(0, 1, 0, 2, 32'h300, 0, "R9");
        cyc(0, 0, 0, 2, 32'h304, 0, "R9");
        wr(6'h0C, qual(1, 0, 1, 0, 0, 0, 0), "R9");
        cyc(0, 1, 0, 2, 32'h308, 0, "R9");
        cyc(0, 1, 0, 2, 32'h30C, 0, "R9");
        tick("R9");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule